// File: doc/BRIEF.md
# Differential Dual-Oscillator Count Comparator

This block measures how far a resistively loaded oscillator lags behind an identical unloaded reference oscillator. On a start request it enables both oscillators in the same cycle and counts the rising edges of each one after bringing them into the system clock domain. The reference count is kept in a 9-bit counter plus a lap counter. When the reference has finished the requested number of full 512-edge laps, both oscillators are disabled in that cycle and the loaded count is captured, including any edge that arrives in that same cycle.

The result is the shortfall of the loaded oscillator: 512 times the lap count, minus the loaded count. A heavier load slows the loaded oscillator, so a larger shortfall means higher resistance. The shortfall is compared with a nominal value, scaled by the lap count and chosen by a transistor-corner code from a separate gate-delay measurement. An out-of-range flag is raised when the gap to the nominal exceeds a tolerance, which is also scaled by the lap count.

If the loaded oscillator reaches the full target no later than the reference, the measurement is invalid. The block then stops at once, forces the difference to zero and flags an error. The results stay on the outputs until the next start.

Top module: `osc_diff_comparator`

## Requirements
- R1: A start pulse while no measurement runs drives `ref_en` and `load_en` high together in the next cycle and clears `done`, `diff`, `out_of_range` and `load_err`.
- R2: Rising edges of each oscillator input are counted from start. In the cycle the reference count reaches 512×laps, both enables drop together and `done` rises.
- R3: `diff` equals 512×laps minus the number of loaded-oscillator rising edges counted up to and including the stop cycle. Both inputs pass through synchronisers of equal latency.
- R4: The lap count is `lap_sel`+1, so `lap_sel` values 0 to 3 select 1 to 4 laps.
- R5: The nominal per-lap difference is chosen by `corner_code`: 0 gives 128, 1 gives 112, 2 gives 144, 3 gives 120, 4 gives 136, and codes 5 to 7 give 128.
- R6: `out_of_range` is 1 when |diff − nominal×laps| > tol×laps.
- R7: If the loaded count reaches 512×laps in the same cycle as the reference or earlier, the measurement stops in that cycle with `load_err`=1, `diff`=0 and `out_of_range`=1.
- R8: A start pulse during a running measurement is ignored. It neither restarts the counters nor changes the stop cycle.
- R9: `lap_sel`, `corner_code` and `tol` are sampled at start, so later changes have no effect. The results and `done` hold until the next accepted start.
- R10: After reset the enables, `done`, `diff`, `out_of_range` and `load_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Measurement request pulse |
| lap_sel | input | 2 | Lap count minus one |
| corner_code | input | 3 | Transistor corner from the gate-delay measurement |
| tol | input | 8 | Per-lap tolerance on the difference |
| ref_osc | input | 1 | Unloaded reference oscillator output |
| load_osc | input | 1 | Resistively loaded oscillator output |
| ref_en | output | 1 | Enable of the reference oscillator |
| load_en | output | 1 | Enable of the loaded oscillator |
| diff | output | 12 | 512×laps minus the loaded count |
| out_of_range | output | 1 | Difference outside nominal ± tolerance |
| load_err | output | 1 | Loaded oscillator reached the target first |
| done | output | 1 | Result valid |

## Verification
The hardest case to reach from the ports is an exact tie. Here the loaded oscillator's final edge lands in the very cycle the reference completes its last lap, and that must count as an error rather than a zero difference. The bench models both oscillators as gated toggles that run only while their enable is high, so their phases line up exactly from the enabling edge. Giving both the same half-period then produces the tie, and a shorter loaded half-period makes the loaded oscillator win outright. The expected loaded edge count is the number of loaded rising edges no later than the reference's final edge, computed from the two half-periods.

// File: rtl/osc_cmp_pkg.sv
package osc_cmp_pkg;
   typedef enum logic [2:0] {
      CORNER_TT = 3'd0,
      CORNER_FF = 3'd1,
      CORNER_SS = 3'd2,
      CORNER_FS = 3'd3,
      CORNER_SF = 3'd4
   } corner_e;

   function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
      return (a >= b) ? (a - b) : (b - a);
   endfunction
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_in,
   output logic rise_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("osc_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= osc_in;
   end

   for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/lap_ref_counter.sv
module lap_ref_counter #(
   parameter int CW    = 9,
   parameter int LAP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [LAP_W-1:0] laps_m1,
   output logic             last_o
);
   localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

   logic [CW-1:0]    cnt_q;
   logic [LAP_W-1:0] lap_q;
   logic             wrap;

   assign wrap   = inc && (cnt_q == CNT_TOP);
   assign last_o = wrap && (lap_q == laps_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lap_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
         lap_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
         if (wrap) lap_q <= lap_q + 1'b1;
      end
   end

   // R2: a lap never advances past the last requested lap while counting
   a_r2_lap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> (lap_q <= laps_m1));
endmodule

// File: rtl/load_counter.sv
module load_counter #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [DW-1:0] limit,
   output logic [DW-1:0] next_o,
   output logic          hit_o
);
   logic [DW-1:0] cnt_q;

   assign next_o = inc ? (cnt_q + 1'b1) : cnt_q;
   assign hit_o  = inc && (next_o == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= next_o;
   end

   // R3: the loaded count never climbs past the target
   a_r3_load_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q <= limit));
endmodule

// File: rtl/corner_judge.sv
module corner_judge
   import osc_cmp_pkg::*;
#(
   parameter int DW        = 12,
   parameter int LAP_W     = 2,
   parameter int TOL_W     = 8,
   parameter int NOM_W     = 9,
   parameter int NOM_TT    = 128,
   parameter int NOM_FF    = 112,
   parameter int NOM_SS    = 144,
   parameter int NOM_FS    = 120,
   parameter int NOM_SF    = 136,
   parameter bit TOL_SCALE = 1'b1
) (
   input  logic [2:0]       corner,
   input  logic [LAP_W-1:0] laps_m1,
   input  logic [TOL_W-1:0] tol,
   input  logic [DW-1:0]    diff,
   output logic [NOM_W-1:0] nom_o,
   output logic             oor_o
);
   localparam int JW = DW + TOL_W + 1;

   generate
      if (NOM_TT >= (1 << NOM_W) || NOM_FF >= (1 << NOM_W) || NOM_SS >= (1 << NOM_W) ||
          NOM_FS >= (1 << NOM_W) || NOM_SF >= (1 << NOM_W)) begin : g_bad_nom
         $error("corner_judge: nominal value does not fit NOM_W");
      end
   endgenerate

   always_comb begin
      case (corner_e'(corner))
         CORNER_FF: nom_o = NOM_W'(NOM_FF);
         CORNER_SS: nom_o = NOM_W'(NOM_SS);
         CORNER_FS: nom_o = NOM_W'(NOM_FS);
         CORNER_SF: nom_o = NOM_W'(NOM_SF);
         default:   nom_o = NOM_W'(NOM_TT);
      endcase
   end

   logic [JW-1:0] laps;
   logic [JW-1:0] nom_scaled;
   logic [JW-1:0] tol_scaled;
   logic [JW-1:0] diff_w;
   logic [JW-1:0] gap;

   assign laps       = JW'(laps_m1) + JW'(1);
   assign nom_scaled = JW'(nom_o) * laps;
   assign diff_w     = JW'(diff);

   generate
      if (TOL_SCALE) begin : g_tol_scaled
         assign tol_scaled = JW'(tol) * laps;
      end else begin : g_tol_fixed
         assign tol_scaled = JW'(tol);
      end
   endgenerate

   assign gap   = (diff_w >= nom_scaled) ? (diff_w - nom_scaled) : (nom_scaled - diff_w);
   assign oor_o = (gap > tol_scaled);
endmodule

// File: rtl/osc_diff_comparator.sv
module osc_diff_comparator #(
   parameter int CW          = 9,
   parameter int LAP_W       = 2,
   parameter int TOL_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NOM_TT      = 128,
   parameter int NOM_FF      = 112,
   parameter int NOM_SS      = 144,
   parameter int NOM_FS      = 120,
   parameter int NOM_SF      = 136,
   parameter bit TOL_SCALE   = 1'b1,
   localparam int DW         = CW + LAP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAP_W-1:0] lap_sel,
   input  logic [2:0]       corner_code,
   input  logic [TOL_W-1:0] tol,
   input  logic             ref_osc,
   input  logic             load_osc,
   output logic             ref_en,
   output logic             load_en,
   output logic [DW-1:0]    diff,
   output logic             out_of_range,
   output logic             load_err,
   output logic             done
);
   generate
      if (CW < 2 || LAP_W < 1 || TOL_W < 1) begin : g_bad
         $error("osc_diff_comparator: width parameter out of range");
      end
   endgenerate

   logic             run_q, done_q, err_q, oor_q;
   logic [DW-1:0]    diff_q;
   logic [LAP_W-1:0] laps_m1_q;
   logic [2:0]       corner_q;
   logic [TOL_W-1:0] tol_q;

   logic ref_rise, load_rise;
   logic ref_last, load_hit;
   logic start_ok, stop;
   logic [DW-1:0] target, load_next, diff_calc;
   logic [CW-1:0] nom_sel;
   logic          oor_calc;

   osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .osc_in(ref_osc), .rise_o(ref_rise));

   osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_load_sync (
      .clk(clk), .rst_n(rst_n), .osc_in(load_osc), .rise_o(load_rise));

   assign start_ok = start && !run_q;
   assign target   = (DW'(laps_m1_q) + DW'(1)) << CW;

   lap_ref_counter #(.CW(CW), .LAP_W(LAP_W)) u_ref_cnt (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(run_q && ref_rise),
      .laps_m1(laps_m1_q), .last_o(ref_last));

   load_counter #(.DW(DW)) u_load_cnt (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(run_q && load_rise),
      .limit(target), .next_o(load_next), .hit_o(load_hit));

   assign stop      = run_q && (ref_last || load_hit);
   assign diff_calc = load_hit ? '0 : (target - load_next);

   corner_judge #(
      .DW(DW), .LAP_W(LAP_W), .TOL_W(TOL_W), .NOM_W(CW),
      .NOM_TT(NOM_TT), .NOM_FF(NOM_FF), .NOM_SS(NOM_SS),
      .NOM_FS(NOM_FS), .NOM_SF(NOM_SF), .TOL_SCALE(TOL_SCALE)
   ) u_judge (
      .corner(corner_q), .laps_m1(laps_m1_q), .tol(tol_q),
      .diff(diff_calc), .nom_o(nom_sel), .oor_o(oor_calc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         oor_q     <= 1'b0;
         diff_q    <= '0;
         laps_m1_q <= '0;
         corner_q  <= '0;
         tol_q     <= '0;
      end else if (start_ok) begin
         run_q     <= 1'b1;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         oor_q     <= 1'b0;
         diff_q    <= '0;
         laps_m1_q <= lap_sel;
         corner_q  <= corner_code;
         tol_q     <= tol;
      end else if (stop) begin
         run_q  <= 1'b0;
         done_q <= 1'b1;
         err_q  <= load_hit;
         oor_q  <= load_hit || oor_calc;
         diff_q <= diff_calc;
      end
   end

   assign ref_en       = run_q;
   assign load_en      = run_q;
   assign diff         = diff_q;
   assign out_of_range = oor_q;
   assign load_err     = err_q;
   assign done         = done_q;

   // R1: an accepted start enables both oscillators in the next cycle
   a_r1_enable_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ref_en) |=> (ref_en && load_en && !done));

   // R2: the enables only fall together with the result becoming valid
   a_r2_stop_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_en) |-> (done && !load_en));

   // R7: an error result always reads as zero difference and out of range
   a_r7_err_zero_diff: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> (diff == '0 && out_of_range && done));

   // R8: a start during a run does not drop the enables or raise done
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_en && start && !stop) |=> (ref_en && !done));

   // R9: results hold while no new start is accepted
   a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(diff) && $stable(out_of_range) && $stable(load_err)));

   // R3: the stop request never survives into the idle state
   a_r3_stop_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !ref_en);
endmodule

// File: tb/osc_diff_comparator_tb.sv
`timescale 1ns/1ps
module osc_diff_comparator_tb_top;
   localparam int PR  = 3;      // reference half period in clock cycles
   localparam int NV  = 8;
   localparam int WDOG = 40000;

   // stimulus vectors: loaded half period, lap_sel, corner_code, tol
   localparam int V_PL  [NV] = '{4, 5, 4, 6, 4, 5, 4, 5};
   localparam int V_LS  [NV] = '{0, 0, 1, 0, 0, 1, 3, 0};
   localparam int V_CC  [NV] = '{0, 1, 2, 3, 4, 7, 0, 2};
   localparam int V_TOL [NV] = '{0, 100, 10, 0, 8, 20, 0, 61};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  lap_sel = '0;
   logic [2:0]  corner_code = '0;
   logic [7:0]  tol = '0;
   logic        ref_osc = 1'b0, load_osc = 1'b0;
   logic        ref_en, load_en, out_of_range, load_err, done;
   logic [11:0] diff;

   int n_checks = 0, n_bad = 0;
   int load_half = 4;
   int rc = 0, lc = 0;
   bit en_split = 1'b0;

   always #2.5 clk = ~clk;

   osc_diff_comparator dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .lap_sel(lap_sel),
      .corner_code(corner_code), .tol(tol), .ref_osc(ref_osc), .load_osc(load_osc),
      .ref_en(ref_en), .load_en(load_en), .diff(diff), .out_of_range(out_of_range),
      .load_err(load_err), .done(done));

   // gated oscillator models: run only while enabled, phase aligned at enable
   always @(posedge clk) begin
      if (!ref_en) begin ref_osc <= 1'b0; rc <= 0; end
      else if (rc == PR - 1) begin ref_osc <= ~ref_osc; rc <= 0; end
      else rc <= rc + 1;
      if (!load_en) begin load_osc <= 1'b0; lc <= 0; end
      else if (lc == load_half - 1) begin load_osc <= ~load_osc; lc <= 0; end
      else lc <= lc + 1;
   end

   always @(negedge clk) if (ref_en !== load_en) en_split = 1'b1;

   function automatic int nominal(input int cc);
      case (cc)
         1: return 112;
         2: return 144;
         3: return 120;
         4: return 136;
         default: return 128;
      endcase
   endfunction

   task automatic expect_result(input int pl, input int ls, input int cc, input int tl,
                                output int e_diff, output int e_oor, output int e_err);
      int laps, n, t, m, gap;
      laps = ls + 1;
      n = 512 * laps;
      t = (2 * n - 1) * PR;
      m = ((t / pl) + 1) / 2;
      if (m >= n) begin
         e_diff = 0; e_oor = 1; e_err = 1;
      end else begin
         e_diff = n - m;
         e_err  = 0;
         gap = (e_diff > nominal(cc) * laps) ? e_diff - nominal(cc) * laps : nominal(cc) * laps - e_diff;
         e_oor = (gap > tl * laps) ? 1 : 0;
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(output int cycles);
      cycles = 0;
      while (!done && cycles < WDOG) begin
         @(negedge clk);
         cycles++;
      end
      if (!done) check("watchdog", 0, 1);
   endtask

   task automatic run_vec(input int pl, input int ls, input int cc, input int tl,
                          input string req, output int cycles);
      int ed, eo, ee;
      load_half = pl; lap_sel = 2'(ls); corner_code = 3'(cc); tol = 8'(tl);
      en_split = 1'b0;
      pulse_start();
      check({req, " R1 enables high"}, int'(ref_en && load_en && !done), 1);
      wait_done(cycles);
      expect_result(pl, ls, cc, tl, ed, eo, ee);
      check({req, " R2 enables low at done"}, int'(ref_en || load_en), 0);
      check({req, " R2 enables together"}, int'(en_split), 0);
      check({req, " R3 diff"}, int'(diff), ed);
      check({req, " R6 out_of_range"}, int'(out_of_range), eo);
      check({req, " R7 load_err"}, int'(load_err), ee);
   endtask

   initial begin
      int cyc, base_cyc, ed, eo, ee;
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 ref_en", int'(ref_en), 0);
      check("R10 load_en", int'(load_en), 0);
      check("R10 done", int'(done), 0);
      check("R10 diff", int'(diff), 0);
      check("R10 flags", int'(out_of_range || load_err), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R3 R4 R5 R6 over laps, corners and tolerances
      for (int i = 0; i < NV; i++) begin
         run_vec(V_PL[i], V_LS[i], V_CC[i], V_TOL[i], $sformatf("vec%0d R4 R5", i), cyc);
         repeat (4) @(negedge clk);
      end

      // R7: tie, loaded as fast as reference
      run_vec(PR, 0, 0, 255, "tie R7", cyc);
      // R7: loaded faster, stops early
      run_vec(2, 1, 0, 0, "fast R7", cyc);
      check("fast R7 early stop", int'(cyc < 1024 * 2 * PR), 1);

      // R9: results hold, settings sampled at start
      repeat (20) @(negedge clk);
      check("R9 done held", int'(done), 1);
      check("R9 diff held", int'(diff), 0);

      run_vec(4, 0, 2, 10, "base R8", base_cyc);
      load_half = 4; lap_sel = 2'd0; corner_code = 3'd2; tol = 8'd10;
      pulse_start();
      corner_code = 3'd0; tol = 8'd255; lap_sel = 2'd3;   // R9 changes after start
      repeat (600) @(negedge clk);
      pulse_start();                                       // R8 start while busy
      check("R8 still running", int'(ref_en && !done), 1);
      wait_done(cyc);
      expect_result(4, 0, 2, 10, ed, eo, ee);
      check("R8 stop cycle unchanged", cyc + 602, base_cyc);
      check("R9 diff uses start settings", int'(diff), ed);
      check("R9 oor uses start corner", int'(out_of_range), eo);

      // R1: a new start clears the previous results
      pulse_start();
      check("R1 results cleared", int'(done || load_err || out_of_range || diff != 0), 0);
      wait_done(cyc);

      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_bad++;
      $display("FAIL watchdog global actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule